// File: doc/BRIEF.md
# Cascaded Three-Channel Interval Timer

This block is a programmable timer with three 16-bit down-counters behind an 8-bit register port. Bus addresses 0, 1 and 2 reach the counters one byte at a time. Address 3 takes a control word that selects a counter and sets its counting mode. Channel 0 runs as a free rate generator on the input clock and brings out one pulse per period, which can serve as a baud reference. Channel 1 also counts the input clock, and each of its terminal counts sets a sticky tick interrupt. Channel 2 does not see the clock. It steps once for every channel-1 terminal count, so the interval it measures is a whole number of ticks. When it expires it sets a sticky interval interrupt.

The block accepts a reduced set of control words: binary counting, a full low-then-high 16-bit load, and either a one-shot mode or a rate-generator mode. Any other control word leaves every channel untouched and sets a sticky error flag. Software reads a counter with two accesses. The first access returns the low byte and freezes a snapshot of the whole count. The second access returns the high byte of that snapshot.

Each channel has its own state machine with four states. CH_IDLE is entered after reset or after a control word and holds the count. CH_HALF is entered after a low-byte load and holds the count. CH_RUN counts. CH_SPENT is the one-shot end and holds zero. The transitions are:
- cfg (any state to CH_IDLE)
- load_lo (to CH_HALF)
- load_hi (to CH_RUN)
- expire_oneshot (CH_RUN to CH_SPENT)
- reload_rate (CH_RUN to CH_RUN)

Top module: `casc_timer`

## Requirements
- R1: After reset all three irq/error outputs and `baud_pulse` are 0, every channel is in CH_IDLE with count 0, and every byte toggle points at the low byte.
- R2: A write to address 3 is accepted only when all of these hold: bits 7:6 (channel select) are 0, 1 or 2; bit 0 (BCD) is 0; bits 5:4 are 2'b11; bits 3:1 are 3'b000 (one-shot) or 3'b010 (rate). Any other word sets `mode_err`, which stays set until reset, and changes no channel state, count or toggle.
- R3: Each channel has one byte toggle that is shared by reads and writes. Every data access to the channel flips it, low byte first. An accepted control word for the channel resets it to low.
- R4: A low-byte write loads count[7:0] and preset[7:0] and halts the channel (CH_HALF). A high-byte write loads bits 15:8 and starts counting (CH_RUN). Nothing counts between the two writes.
- R5: In rate mode a running channel with preset N asserts its terminal count on every N-th step and reloads N. Channel 1 steps every clock, so `tick_irq` sets N clock edges after the high-byte load edge and then every N edges.
- R6: In one-shot mode a running channel asserts its terminal count once when its count goes from 1 to 0. It then stays at 0 and gives no further terminal count until it is reloaded.
- R7: Channel 2 steps only on a channel-1 terminal count. With preset M it sets `intvl_irq` on the M-th tick after its load. In rate mode it reloads M and fires again M ticks later.
- R8: In one-shot mode channel 2 sets `intvl_irq` once and is not set again by later ticks. Reading it back returns 0.
- R9: A low-byte read captures the full 16-bit count. The following high-byte read returns bits 15:8 of that capture, even if the channel has counted since.
- R10: A read of address 3 returns 8'hFF and does not flip any toggle.
- R11: `tick_irq` and `intvl_irq` stay set until their acknowledge input is high at a clock edge. If a new event and an acknowledge meet at the same edge, the flag stays set.
- R12: `baud_pulse` is high during the single clock cycle in which channel 0 holds count 1 while running, so it is high for one cycle in every N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 2 | 0..2 select a channel, 3 the control word |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while `bus_rd` is high |
| tick_ack | input | 1 | Clears `tick_irq` |
| intvl_ack | input | 1 | Clears `intvl_irq` |
| baud_pulse | output | 1 | Channel-0 terminal count pulse |
| tick_irq | output | 1 | Sticky channel-1 tick flag |
| intvl_irq | output | 1 | Sticky channel-2 interval flag |
| mode_err | output | 1 | Sticky flag for a rejected control word |

## Verification
The counting function is exercised with several load patterns, and each one separates a different kind of fault:
- Short presets in rate mode (3 and 5) expose off-by-one errors in the period and a failure to reload.
- A preset of 0x0100 is read while it runs. The low byte wraps under the high byte, so a high-byte read that is not taken from the snapshot would differ from the expected value.
- Loading channel 2 while channel 1 is stopped, then restarting channel 1, fixes the phase of the cascade. This makes the interval edge exact and shows whether channel 2 is stepping on the clock rather than on ticks.
- Each of the four malformed control-word fields is applied alone, so that each rejection condition is tested by itself.
- The low-byte-only write and the acknowledge that arrives on the same edge as an event test the ordering rules.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // Channel lifecycle: idle after config, half-loaded, counting, one-shot done
    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_HALF  = 2'd1,
        CH_RUN   = 2'd2,
        CH_SPENT = 2'd3
    } ch_state_t;

    typedef enum logic {
        OP_ONESHOT = 1'b0,
        OP_RATE    = 1'b1
    } op_mode_t;

    typedef struct packed {
        logic       ok;
        logic [1:0] sel;
        op_mode_t   op;
    } ctl_word_t;

    localparam int NUM_CH = 3;

endpackage

// File: rtl/tmr_ctl_dec.sv
module tmr_ctl_dec
    import tmr_pkg::*;
(
    input  logic [7:0] word,
    output ctl_word_t  dec
);
    logic [1:0] sel_f;
    logic [1:0] load_f;
    logic [2:0] mode_f;
    logic       bcd_f;
    logic       mode_ok;

    always_comb begin
        sel_f   = word[7:6];
        load_f  = word[5:4];
        mode_f  = word[3:1];
        bcd_f   = word[0];
        mode_ok = (mode_f == 3'b000) || (mode_f == 3'b010);
        dec.sel = sel_f;
        dec.op  = (mode_f == 3'b010) ? OP_RATE : OP_ONESHOT;
        dec.ok  = (sel_f != 2'd3) && !bcd_f && (load_f == 2'b11) && mode_ok;
    end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_pkg::*;
#(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  op_mode_t      cfg_op,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [BW-1:0] wdata,
    input  logic          step,
    output logic [BW-1:0] rdata,
    output logic          tc
);
    localparam int CW = 2 * BW;

    ch_state_t     state, state_nx;
    op_mode_t      op_q;
    logic [CW-1:0] cnt_q, preset_q, snap_q;
    logic          hi_sel_q;
    logic          at_one;

    assign at_one = (cnt_q == CW'(1));
    assign tc     = (state == CH_RUN) && step && at_one && !cfg_we && !wr_en;

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            CH_IDLE, CH_HALF, CH_SPENT: state_nx = state;
            CH_RUN: if (tc && op_q == OP_ONESHOT) state_nx = CH_SPENT;
        endcase
        if (cfg_we)     state_nx = CH_IDLE;
        else if (wr_en) state_nx = hi_sel_q ? CH_RUN : CH_HALF;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= CH_IDLE;
        else        state <= state_nx;
    end

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q     <= OP_ONESHOT;
            cnt_q    <= '0;
            preset_q <= '0;
            snap_q   <= '0;
            hi_sel_q <= 1'b0;
        end else begin
            if (cfg_we) begin
                op_q     <= cfg_op;
                hi_sel_q <= 1'b0;
            end else if (wr_en) begin
                hi_sel_q <= !hi_sel_q;
                if (hi_sel_q) begin
                    cnt_q[CW-1:BW]    <= wdata;
                    preset_q[CW-1:BW] <= wdata;
                end else begin
                    cnt_q[BW-1:0]    <= wdata;
                    preset_q[BW-1:0] <= wdata;
                end
            end else begin
                if (rd_en) begin
                    hi_sel_q <= !hi_sel_q;
                    if (!hi_sel_q) snap_q <= cnt_q;
                end
                if (state == CH_RUN && step) begin
                    if (at_one) cnt_q <= (op_q == OP_RATE) ? preset_q : '0;
                    else        cnt_q <= cnt_q - CW'(1);
                end
            end
        end
    end

    always_comb rdata = hi_sel_q ? snap_q[CW-1:BW] : cnt_q[BW-1:0];

    a_r6_spent_holds_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_SPENT && !cfg_we && !wr_en) |=> (cnt_q == '0));

    a_r4_half_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_HALF && !cfg_we && !wr_en) |=> $stable(cnt_q));

    a_r3_cfg_low_first: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> !hi_sel_q);
endmodule

// File: rtl/casc_timer.sv
module casc_timer
    import tmr_pkg::*;
#(
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [1:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic             tick_ack,
    input  logic             intvl_ack,
    output logic             baud_pulse,
    output logic             tick_irq,
    output logic             intvl_irq,
    output logic             mode_err
);
    localparam logic [1:0] CTL_ADDR = 2'd3;
    localparam int         TICK_CH  = NUM_CH - 2;
    localparam int         IVL_CH   = NUM_CH - 1;

    ctl_word_t        dec;
    logic             ctl_wr;
    logic [NUM_CH-1:0] tc_v;
    logic [BUS_W-1:0]  rd_v [NUM_CH];

    assign ctl_wr = bus_wr && (bus_addr == CTL_ADDR);

    tmr_ctl_dec u_dec (
        .word (bus_wdata[7:0]),
        .dec  (dec)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic step_i;
        if (i == IVL_CH) begin : g_casc
            assign step_i = tc_v[TICK_CH];
        end else begin : g_free
            assign step_i = 1'b1;
        end
        tmr_chan #(.BW(BUS_W)) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .cfg_we (ctl_wr && dec.ok && (dec.sel == 2'(i))),
            .cfg_op (dec.op),
            .wr_en  (bus_wr && (bus_addr == 2'(i))),
            .rd_en  (bus_rd && (bus_addr == 2'(i))),
            .wdata  (bus_wdata),
            .step   (step_i),
            .rdata  (rd_v[i]),
            .tc     (tc_v[i])
        );
    end

    always_comb begin
        unique case (bus_addr)
            2'd0:    bus_rdata = rd_v[0];
            2'd1:    bus_rdata = rd_v[1];
            2'd2:    bus_rdata = rd_v[2];
            default: bus_rdata = '1;
        endcase
    end

    assign baud_pulse = tc_v[0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_irq  <= 1'b0;
            intvl_irq <= 1'b0;
            mode_err  <= 1'b0;
        end else begin
            if (tc_v[TICK_CH])  tick_irq <= 1'b1;
            else if (tick_ack)  tick_irq <= 1'b0;
            if (tc_v[IVL_CH])   intvl_irq <= 1'b1;
            else if (intvl_ack) intvl_irq <= 1'b0;
            if (ctl_wr && !dec.ok) mode_err <= 1'b1;
        end
    end

    a_r10_ctl_read_ff: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == CTL_ADDR) |-> (bus_rdata == '1));

    a_r11_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_irq && !tick_ack) |=> tick_irq);

    a_r5_tick_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tick_irq) |-> $past(tc_v[TICK_CH]));

    a_r7_intvl_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(intvl_irq) |-> $past(tc_v[IVL_CH]));

    a_r2_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err |=> mode_err);
endmodule

// File: tb/casc_timer_bench.sv
module casc_timer_bench;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       tick_ack = 1'b0, intvl_ack = 1'b0;
    logic       baud_pulse, tick_irq, intvl_irq, mode_err;
    int         n_chk = 0, n_bad = 0;
    bit         done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    casc_timer u_casc_timer (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick_ack(tick_ack), .intvl_ack(intvl_ack), .baud_pulse(baud_pulse),
        .tick_irq(tick_irq), .intvl_irq(intvl_irq), .mode_err(mode_err)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk); @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic ack_tick();
        tick_ack = 1'b1; @(posedge clk); @(negedge clk); tick_ack = 1'b0;
    endtask

    task automatic ack_intvl();
        intvl_ack = 1'b1; @(posedge clk); @(negedge clk); intvl_ack = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wait_n(3); rst_n = 1'b1; wait_n(1);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        do_reset();
        chk("R1 tick_irq", tick_irq, 0);
        chk("R1 intvl_irq", intvl_irq, 0);
        chk("R1 mode_err", mode_err, 0);
        chk("R1 baud_pulse", baud_pulse, 0);
        rd(2'd0, v); chk("R1 ch0 low", v, 8'h00);
        rd(2'd0, v); chk("R1 ch0 high", v, 8'h00);
    endtask

    task automatic t_bad_fields();
        logic [7:0] bad [4] = '{8'hF4, 8'hB5, 8'hB8, 8'h94};
        for (int i = 0; i < 4; i++) begin
            do_reset();
            wr(2'd3, bad[i]);
            chk("R2 reject field", mode_err, 1);
        end
        do_reset();
    endtask

    task automatic t_readback();
        logic [7:0] v;
        wr(2'd3, 8'hB4);
        chk("R2 good word no err", mode_err, 0);
        wr(2'd2, 8'h34); wr(2'd2, 8'h12);
        rd(2'd2, v); chk("R3 ch2 low", v, 8'h34);
        rd(2'd2, v); chk("R3 ch2 high", v, 8'h12);
        wr(2'd3, 8'hB5);
        chk("R2 bcd err", mode_err, 1);
        rd(2'd2, v); chk("R2 ch2 low kept", v, 8'h34);
        rd(2'd2, v); chk("R2 ch2 high kept", v, 8'h12);
    endtask

    task automatic t_ctl_read();
        logic [7:0] v;
        rd(2'd3, v); chk("R10 addr3 reads FF", v, 8'hFF);
        rd(2'd2, v); chk("R10 toggle untouched low", v, 8'h34);
        rd(2'd2, v); chk("R10 toggle untouched high", v, 8'h12);
    endtask

    task automatic t_baud();
        wr(2'd3, 8'h34); wr(2'd0, 8'h03); wr(2'd0, 8'h00);
        wait_n(1); chk("R12 k1", baud_pulse, 0);
        wait_n(1); chk("R12 k2", baud_pulse, 1);
        wait_n(1); chk("R12 k3 reload", baud_pulse, 0);
        wait_n(1); chk("R12 k4", baud_pulse, 0);
        wait_n(1); chk("R12 k5", baud_pulse, 1);
    endtask

    task automatic t_snapshot();
        logic [7:0] v;
        wr(2'd3, 8'h34); wr(2'd0, 8'h00); wr(2'd0, 8'h01);
        rd(2'd0, v); chk("R9 snap low", v, 8'h00);
        wait_n(3);
        rd(2'd0, v); chk("R9 snap high", v, 8'h01);
    endtask

    task automatic t_tick();
        wr(2'd3, 8'h74); ack_tick();
        wr(2'd1, 8'h05); wr(2'd1, 8'h00);
        wait_n(4); chk("R5 tick k4", tick_irq, 0);
        wait_n(1); chk("R5 tick k5", tick_irq, 1);
        ack_tick(); chk("R11 ack clears", tick_irq, 0);
        wait_n(4); chk("R5 tick k10 reload", tick_irq, 1);
        wait_n(4); ack_tick(); chk("R11 set beats ack", tick_irq, 1);
        ack_tick(); chk("R11 ack after", tick_irq, 0);
    endtask

    task automatic t_halt();
        wr(2'd3, 8'h74); wr(2'd1, 8'h03); wr(2'd1, 8'h00);
        wr(2'd1, 8'h07); ack_tick();
        wait_n(12); chk("R4 halted", tick_irq, 0);
        wr(2'd1, 8'h00);
        wait_n(6); chk("R4 k6", tick_irq, 0);
        wait_n(1); chk("R4 k7 run", tick_irq, 1);
    endtask

    task automatic t_cascade();
        logic [7:0] v;
        wr(2'd3, 8'h74); wr(2'd3, 8'hB4);
        wr(2'd2, 8'h03); wr(2'd2, 8'h00);
        ack_intvl(); ack_tick();
        wr(2'd1, 8'h05); wr(2'd1, 8'h00);
        wait_n(7);
        rd(2'd2, v); chk("R7 ch2 after one tick low", v, 8'h02);
        rd(2'd2, v); chk("R7 ch2 high", v, 8'h00);
        wait_n(5); chk("R7 intvl k14", intvl_irq, 0);
        wait_n(1); chk("R7 intvl k15", intvl_irq, 1);
        ack_intvl();
        wait_n(13); chk("R7 intvl k29", intvl_irq, 0);
        wait_n(1); chk("R7 intvl k30 reload", intvl_irq, 1);
    endtask

    task automatic t_oneshot();
        logic [7:0] v;
        wr(2'd3, 8'h74); wr(2'd3, 8'hB0);
        wr(2'd2, 8'h02); wr(2'd2, 8'h00);
        ack_intvl();
        wr(2'd1, 8'h05); wr(2'd1, 8'h00);
        wait_n(9); chk("R8 k9", intvl_irq, 0);
        wait_n(1); chk("R8 k10", intvl_irq, 1);
        ack_intvl(); chk("R8 ack", intvl_irq, 0);
        wait_n(14); chk("R8 no refire", intvl_irq, 0);
        rd(2'd2, v); chk("R8 ch2 zero low", v, 8'h00);
        rd(2'd2, v); chk("R8 ch2 zero high", v, 8'h00);
        wr(2'd3, 8'h70); ack_tick();
        wr(2'd1, 8'h03); wr(2'd1, 8'h00);
        wait_n(2); chk("R6 k2", tick_irq, 0);
        wait_n(1); chk("R6 k3", tick_irq, 1);
        ack_tick();
        wait_n(10); chk("R6 no refire", tick_irq, 0);
        rd(2'd1, v); chk("R6 ch1 zero low", v, 8'h00);
        rd(2'd1, v); chk("R6 ch1 zero high", v, 8'h00);
    endtask

    initial begin
        t_reset();
        t_bad_fields();
        t_readback();
        t_ctl_read();
        t_baud();
        t_snapshot();
        t_tick();
        t_halt();
        t_cascade();
        t_oneshot();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog all-R actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule